// File: doc/BRIEF.md
# Transmit Serial Bus Frame Timebase

This block keeps the timing position of a transmit serial system bus that carries T1 or E1 channel data. It counts bit times within an 8-bit channel slot, slots within a 256-bit frame (32 slots of 8 bits, 125 µs at 2.048 Mb/s), and frames within a 48-frame multiframe (6 ms). It exports the current slot index, the bit index within the slot, the frame index and a flag for the first frame of the multiframe. Downstream framing logic uses these outputs to steer channel data.

Each of the two sync pins, frame and multiframe, has its own direction setting. As an output, the pin carries a one-clock pulse when the position reaches a programmable bit offset inside the frame. For the multiframe pin, this happens only in frame 0. As an input, a rising edge marks the bit in which it is seen as the offset bit, and the counters are realigned to match. The multiframe pin also forces frame 0. Between sync events the counters free-run.

A double-rate option takes a bus clock at twice the bit rate, so each bit lasts two clocks. Two phase selects then choose which half of the bit time strobes data and which half samples or drives sync. All configuration inputs are static. They are captured while reset is held and again at every frame boundary, so a change takes effect at the start of the next frame.

Top module: `txbus_timebase`

## Requirements
- R1: While rst_n is low (synchronous, active low), the position goes to slot 0, bit 0, frame 0 with mf_first high. The configuration inputs are captured every reset cycle.
- R2: The position is the bit number slot_idx*8+bit_idx within the frame, from 0 to 255. It steps by one per bit time and wraps from 255 to 0. Frame_idx advances on that wrap and runs from 0 to 47. mf_first is high exactly when frame_idx is 0.
- R3: With cfg_fs_dir_in=0, fs_out is high on a sync-strobe cycle whose bit position equals cfg_offset, and low otherwise. That is one clock per frame. With cfg_fs_dir_in=1, fs_out stays low.
- R4: With cfg_ms_dir_in=0, ms_out follows the rule of R3 but only in frame 0, so it coincides with a frame pulse once per 48 frames. With cfg_ms_dir_in=1, ms_out stays low.
- R5: With cfg_fs_dir_in=1, a low-to-high change of fs_in seen on a sync-strobe cycle makes the current bit time the offset bit. The next bit position is cfg_offset+1. The frame index is unchanged, except that it advances when cfg_offset is 255.
- R6: With cfg_ms_dir_in=1, a rising ms_in seen on a sync-strobe cycle makes the current bit time the offset bit of frame 0. The next position is cfg_offset+1 in frame 0, or bit 0 of frame 1 when cfg_offset is 255. This takes precedence over a frame sync edge.
- R7: A sync pin set as an output ignores its input. A held-high input level with no new rising edge causes no realignment.
- R8: After the last input sync edge, the counters keep running with 256-bit frames and 48-frame multiframes.
- R9: With cfg_dbl_rate=1, each bit time lasts two clocks, phase 0 followed by phase 1. The position changes only after phase 1. Each frame starts in phase 0.
- R10: With cfg_dbl_rate=1, data_stb is high only on clocks whose phase equals cfg_data_late, and sync_stb only on clocks whose phase equals cfg_sync_late. Sync inputs are sampled, and sync outputs driven, only on sync_stb clocks. With cfg_dbl_rate=0, both strobes are high on every clock.
- R11: A configuration change made during a frame has no effect until the position wraps to bit 0 of the next frame.
- R12: In double rate, a sync edge sampled in phase 0 still realigns the counters at the end of that same bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (bit rate, or twice bit rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fs_dir_in | input | 1 | 1: frame sync pin is an input |
| cfg_ms_dir_in | input | 1 | 1: multiframe sync pin is an input |
| cfg_offset | input | 8 | Sync bit offset within the frame |
| cfg_dbl_rate | input | 1 | 1: clock runs at twice the bit rate |
| cfg_data_late | input | 1 | Data strobe phase in double rate |
| cfg_sync_late | input | 1 | Sync strobe phase in double rate |
| fs_in | input | 1 | Frame sync input level |
| ms_in | input | 1 | Multiframe sync input level |
| fs_out | output | 1 | Frame sync output pulse |
| ms_out | output | 1 | Multiframe sync output pulse |
| data_stb | output | 1 | Data sampling strobe |
| sync_stb | output | 1 | Sync sampling and drive strobe |
| slot_idx | output | 5 | Current slot within the frame |
| bit_idx | output | 3 | Current bit within the slot |
| frame_idx | output | 6 | Current frame within the multiframe |
| mf_first | output | 1 | High during frame 0 |

## Verification
The assertions assume that the slot and frame sizes are powers of two where stated, so the bit counter wraps by overflow. They also assume that configuration is steady in the cycles they inspect, since realignment checks use the offset captured at the previous clock. The stimulus changes configuration and sync levels only on the falling clock edge. Each change is followed by enough cycles for the next frame boundary to load it. Sync edges are driven both in phase 0 and in phase 1 of double-rate bit times, and with the offset at both ends of the frame.

// File: rtl/txbus_timebase.sv
module txbus_timebase #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int FRAMES    = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_fs_dir_in,
  input  logic cfg_ms_dir_in,
  input  logic [$clog2(SLOTS*SLOT_BITS)-1:0] cfg_offset,
  input  logic cfg_dbl_rate,
  input  logic cfg_data_late,
  input  logic cfg_sync_late,
  input  logic fs_in,
  input  logic ms_in,
  output logic fs_out,
  output logic ms_out,
  output logic data_stb,
  output logic sync_stb,
  output logic [$clog2(SLOTS)-1:0] slot_idx,
  output logic [$clog2(SLOT_BITS)-1:0] bit_idx,
  output logic [$clog2(FRAMES)-1:0] frame_idx,
  output logic mf_first
);
  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int BW = $clog2(FRAME_BITS);
  localparam int TW = $clog2(SLOT_BITS);
  localparam int FW = $clog2(FRAMES);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
  localparam logic [FW-1:0] LAST_FRM = FW'(FRAMES - 1);

  logic q_fs_dir, q_ms_dir, q_dbl, q_dlate, q_slate;
  logic [BW-1:0] q_off, bit_cnt;
  logic [FW-1:0] frm_cnt;
  logic phase, fs_d, ms_d, pend_fs, pend_ms;

  logic adv, fs_rise, ms_rise, do_fs, do_ms, wrap;
  logic [BW-1:0] cur_bit, off_inc, bit_inc;
  logic [FW-1:0] cur_frm;

  assign adv      = !q_dbl || phase;
  assign sync_stb = !q_dbl || (phase == q_slate);
  assign data_stb = !q_dbl || (phase == q_dlate);
  assign fs_rise  = sync_stb && q_fs_dir && fs_in && !fs_d;
  assign ms_rise  = sync_stb && q_ms_dir && ms_in && !ms_d;
  assign do_fs    = fs_rise || pend_fs;
  assign do_ms    = ms_rise || pend_ms;
  assign cur_bit  = (do_ms || do_fs) ? q_off : bit_cnt;
  assign cur_frm  = do_ms ? '0 : frm_cnt;
  assign wrap     = (cur_bit == LAST_BIT);
  assign off_inc  = q_off + 1'b1;
  assign bit_inc  = bit_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      frm_cnt  <= '0;
      phase    <= 1'b0;
      pend_fs  <= 1'b0;
      pend_ms  <= 1'b0;
      fs_d     <= fs_in;
      ms_d     <= ms_in;
      q_fs_dir <= cfg_fs_dir_in;
      q_ms_dir <= cfg_ms_dir_in;
      q_off    <= cfg_offset;
      q_dbl    <= cfg_dbl_rate;
      q_dlate  <= cfg_data_late;
      q_slate  <= cfg_sync_late;
    end else begin
      phase <= q_dbl ? !phase : 1'b0;
      if (sync_stb) begin
        fs_d <= fs_in;
        ms_d <= ms_in;
      end
      if (adv) begin
        bit_cnt <= cur_bit + 1'b1;
        if (wrap) frm_cnt <= (cur_frm == LAST_FRM) ? '0 : cur_frm + 1'b1;
        else      frm_cnt <= cur_frm;
        pend_fs <= 1'b0;
        pend_ms <= 1'b0;
        if (wrap) begin
          q_fs_dir <= cfg_fs_dir_in;
          q_ms_dir <= cfg_ms_dir_in;
          q_off    <= cfg_offset;
          q_dbl    <= cfg_dbl_rate;
          q_dlate  <= cfg_data_late;
          q_slate  <= cfg_sync_late;
        end
      end else begin
        pend_fs <= pend_fs | fs_rise;
        pend_ms <= pend_ms | ms_rise;
      end
    end
  end

  assign fs_out    = !q_fs_dir && sync_stb && (bit_cnt == q_off);
  assign ms_out    = !q_ms_dir && sync_stb && (bit_cnt == q_off) && (frm_cnt == '0);
  assign slot_idx  = bit_cnt[BW-1:TW];
  assign bit_idx   = bit_cnt[TW-1:0];
  assign frame_idx = frm_cnt;
  assign mf_first  = (frm_cnt == '0);

  // R2
  frm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_cnt <= LAST_FRM);

  // R4
  ms_fs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_out && !q_fs_dir) |-> (fs_out && mf_first));

  // R5
  fs_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && do_fs && !do_ms) |=> (bit_cnt == $past(off_inc)));

  // R6
  ms_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && do_ms && q_off != LAST_BIT) |=> (frm_cnt == '0 && bit_cnt == $past(off_inc)));

  // R8
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !do_fs && !do_ms) |=> (bit_cnt == $past(bit_inc)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(bit_cnt) && $stable(frm_cnt)));
endmodule

// File: tb/sim_txbus_timebase.sv
module sim_txbus_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 256;
  localparam int NF = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_fs_dir_in = 1'b0, cfg_ms_dir_in = 1'b0;
  logic [7:0] cfg_offset = 8'd5;
  logic cfg_dbl_rate = 1'b0, cfg_data_late = 1'b0, cfg_sync_late = 1'b0;
  logic fs_in = 1'b0, ms_in = 1'b0;
  logic fs_out, ms_out, data_stb, sync_stb, mf_first;
  logic [4:0] slot_idx;
  logic [2:0] bit_idx;
  logic [5:0] frame_idx;

  txbus_timebase u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string scen = "R1";

  int m_bit, m_frm, m_off;
  bit m_ph, m_fsd, m_msd, m_pfs, m_pms;
  bit m_fsdir, m_msdir, m_dbl, m_dl, m_sl;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s): got %0h expected %0h", req, scen, act, exp);
    end
  endtask

  task automatic load_cfg();
    m_fsdir = cfg_fs_dir_in; m_msdir = cfg_ms_dir_in; m_off = int'(cfg_offset);
    m_dbl = cfg_dbl_rate; m_dl = cfg_data_late; m_sl = cfg_sync_late;
  endtask

  task automatic step();
    bit adv, ss, rf, rm;
    int p;
    if (!rst_n) begin
      m_bit = 0; m_frm = 0; m_ph = 0; m_pfs = 0; m_pms = 0;
      m_fsd = fs_in; m_msd = ms_in;
      load_cfg();
      return;
    end
    adv = !m_dbl || m_ph;
    ss  = !m_dbl || (m_ph == m_sl);
    rf  = ss && m_fsdir && fs_in && !m_fsd;
    rm  = ss && m_msdir && ms_in && !m_msd;
    if (ss) begin m_fsd = fs_in; m_msd = ms_in; end
    if (adv) begin
      p = m_frm * NB + m_bit;
      if (rm || m_pms) p = m_off;
      else if (rf || m_pfs) p = m_frm * NB + m_off;
      p = (p + 1) % (NB * NF);
      m_bit = p % NB; m_frm = p / NB;
      m_pfs = 0; m_pms = 0;
      m_ph = 0;
      if (m_bit == 0) load_cfg();
    end else begin
      m_pfs = m_pfs | rf; m_pms = m_pms | rm;
      m_ph = m_dbl ? !m_ph : 1'b0;
    end
  endtask

  task automatic check_all();
    bit ss, ds, efs, ems;
    ss  = !m_dbl || (m_ph == m_sl);
    ds  = !m_dbl || (m_ph == m_dl);
    efs = !m_fsdir && ss && (m_bit == m_off);
    ems = !m_msdir && ss && (m_bit == m_off) && (m_frm == 0);
    chk("R2", {slot_idx, bit_idx, frame_idx, mf_first},
        {5'(m_bit / 8), 3'(m_bit % 8), 6'(m_frm), 1'(m_frm == 0)});
    chk("R3", fs_out, efs);
    chk("R4", ms_out, ems);
    chk("R10", {data_stb, sync_stb}, {ds, ss});
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      check_all();
      step();
      @(negedge clk);
    end
  endtask

  task automatic run_to(int bitpos, bit phase);
    for (int i = 0; i < 2 * NB * NF; i++) begin
      if (m_bit == bitpos && m_ph == phase) break;
      run(1);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin step(); @(negedge clk); end
    rst_n = 1'b1;
    scen = "R1";
    chk("R1", {slot_idx, bit_idx, frame_idx}, 0);
    chk("R1", mf_first, 1);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    scen = "R2"; run(NB * NF);
    scen = "R3"; run(NB * NF);
    scen = "R11"; run(10); cfg_offset = 8'd200; run(2 * NB);
    scen = "R5"; cfg_fs_dir_in = 1'b1; run(NB + 20);
    run_to(77, 0); fs_in = 1'b1; run(1);
    scen = "R7"; run(60); fs_in = 1'b0;
    scen = "R8"; run(3 * NB);
    scen = "R6"; cfg_ms_dir_in = 1'b1; cfg_offset = 8'd30; run(NB + 5);
    run_to(140, 0); ms_in = 1'b1; fs_in = 1'b1; run(3); ms_in = 1'b0; fs_in = 1'b0;
    scen = "R8"; run(2 * NB);
    scen = "R6"; cfg_offset = 8'd255; run(NB + 5);
    run_to(12, 0); ms_in = 1'b1; run(4); ms_in = 1'b0; run(NB);
    scen = "R5"; cfg_ms_dir_in = 1'b0; run(NB + 5);
    run_to(9, 0); fs_in = 1'b1; run(3); fs_in = 1'b0; run(NB);
    scen = "R7"; cfg_fs_dir_in = 1'b0; cfg_offset = 8'd64; run(NB + 5);
    fs_in = 1'b1; ms_in = 1'b1; run(20); fs_in = 1'b0; ms_in = 1'b0; run(2 * NB);
    scen = "R9"; cfg_dbl_rate = 1'b1; cfg_data_late = 1'b1; cfg_sync_late = 1'b0;
    run(NB + 5); run(4 * NB);
    scen = "R12"; cfg_fs_dir_in = 1'b1; run(4 * NB);
    run_to(100, 0); fs_in = 1'b1; run(6); fs_in = 1'b0; run(2 * NB);
    scen = "R10"; cfg_sync_late = 1'b1; cfg_data_late = 1'b0; run(4 * NB);
    run_to(40, 0); fs_in = 1'b1; run(6); fs_in = 1'b0; run(2 * NB);
    scen = "R4"; cfg_fs_dir_in = 1'b0; cfg_offset = 8'd3; run(4 * NB);
    run_to(0, 0); run(2 * NB * NF);
    scen = "R11"; cfg_dbl_rate = 1'b0; run(2 * NB); run(2 * NB);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog (%s): got timeout expected completion", scen);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule